// File: doc/BRIEF.md
# Multi-register stack push/pop sequencer

This block carries out one 16-bit push or pop instruction word over several clock cycles. When a start strobe arrives, it decodes the word, checks the register range, and then steps through a run of consecutive 16-bit general registers. Each register moves through a single-ported register-file interface and a 16-bit memory port that uses a valid/ready handshake. A 32-bit return-address register can join the transfer. It travels as two halfword beats, with the low half at the lower address.

A pop reads upward from the stack pointer and a push writes downward in mirrored order, so a push followed by a pop of the same word restores every register. The return form of pop ends by presenting a jump whose target is the return address as it stands after the pop. On completion the block pulses done together with either the final stack pointer or an illegal flag. A rejected word leaves registers, memory, the return address and the stack pointer untouched.

Top module: `stack_seq`

## Requirements
- R1: A word with bits 15:9 = 0000001 is a pop (bit 8 return flag, bit 7 return-address flag). A word with bits 15:8 = 00000001 is a push (bit 7 return-address flag). Both use bits 6:4 as the count field and bits 3:0 as the first register index. Any other word completes with illegal_o high.
- R2: The number of registers moved is the count field plus one (1 to 8), and each takes exactly one memory handshake. The return address adds two more.
- R3: If the register count plus the first index exceeds 15, the word is illegal. In that case done_o and illegal_o pulse together one cycle after the start, with no memory, register or return-address access, no jump, and sp_o equal to the starting stack pointer.
- R4: Pop loads registers in ascending index order from the first one. Each load reads the halfword at the current SP, and SP then increases by 2.
- R5: With the return-address flag set, pop loads the return address after the registers: the low half from SP, the high half from SP+2. SP then increases by 4.
- R6: A pop with the return flag set pulses jump_o together with done_o. jump_target_o then equals the return address after the pop; it is unchanged if the return-address flag is clear. Push words and illegal words never raise jump_o.
- R7: With the return-address flag set, push first stores the return address at SP-4 (low half) and SP-2 (high half) and sets SP to SP-4. It then stores registers from the highest index down to the first, decreasing SP by 2 before each store. Memory from the final SP upward then holds the registers in ascending order, followed by the return address.
- R8: An access holds mem_req_o, the address, the write enable and the write data stable until mem_ready_i is high at a clock edge. Nothing advances while ready is low.
- R9: busy_o rises in the cycle after an accepted start and stays high through the done cycle. done_o lasts one cycle. start_i is ignored while busy_o is high.
- R10: For a legal word, sp_o during the done cycle equals the stack pointer after all transfers.
- R11: After reset, busy_o, done_o, mem_req_o, rf_we_o and ra_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| insn_i | input | 16 | Instruction word |
| sp_i | input | ADDR_W | Stack pointer at start |
| ra_i | input | 32 | Current return-address register value |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Word rejected, valid with done_o |
| sp_o | output | ADDR_W | Final stack pointer, valid with done_o |
| jump_o | output | 1 | Return jump request, valid with done_o |
| jump_target_o | output | 32 | Return jump target |
| rf_addr_o | output | 4 | Register-file index |
| rf_rdata_i | input | 16 | Register-file read data for rf_addr_o |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_wdata_o | output | 16 | Register-file write data |
| ra_we_o | output | 1 | Return-address write strobe |
| ra_wdata_o | output | 32 | Return-address write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (high) or read (low) |
| mem_addr_o | output | ADDR_W | Byte address of the halfword |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory handshake ready |

## Verification
A wrong stack-pointer register shows up on mem_addr_o at the very next access and again on sp_o at done. A wrong register index shows on rf_addr_o in the same beat, and it leaves a misplaced halfword in memory or a wrong register that a full compare after the instruction catches. A state machine that skips or repeats a step changes the number of handshakes, and one that hangs keeps busy_o high until the per-instruction cycle limit expires. Every push and pop encoding is swept with both flag settings and a throttled ready, so each of these symptoms appears within the instruction that caused it.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int unsigned HW_W   = 16;
  localparam int unsigned RA_W   = 2 * HW_W;
  localparam int unsigned RIDX_W = 4;
  localparam int unsigned CNT_W  = 3;
  localparam int unsigned CNTX_W = CNT_W + 1;
  localparam int unsigned SPAN_W = RIDX_W + 1;

  localparam logic [6:0] POP_OPC  = 7'b0000001;
  localparam logic [7:0] PUSH_OPC = 8'b00000001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RA_LO,
    ST_RA_HI,
    ST_REG,
    ST_FIN
  } seq_st_e;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              ret;
    logic              with_ra;
    logic [CNTX_W-1:0] cnt;
    logic [RIDX_W-1:0] first;
    logic              bad;
  } dec_t;
endpackage

// File: rtl/stack_seq_decode.sv
module stack_seq_decode
  import stack_seq_pkg::*;
(
  input  logic [15:0] insn_i,
  output dec_t        dec_o
);
  localparam logic [SPAN_W-1:0] MAX_IDX = SPAN_W'((1 << RIDX_W) - 1);

  logic              is_pop, is_push;
  logic [CNTX_W-1:0] cnt;
  logic [RIDX_W-1:0] first;
  logic [SPAN_W-1:0] span;

  always_comb begin
    is_pop  = (insn_i[15:9] == POP_OPC);
    is_push = (insn_i[15:8] == PUSH_OPC);
    cnt     = CNTX_W'(insn_i[6:4]) + CNTX_W'(1);
    first   = insn_i[3:0];
    span    = {1'b0, first} + SPAN_W'(cnt);
    dec_o.push    = is_push;
    dec_o.pop     = is_pop;
    dec_o.ret     = is_pop & insn_i[8];
    dec_o.with_ra = insn_i[7];
    dec_o.cnt     = cnt;
    dec_o.first   = first;
    dec_o.bad     = !(is_pop | is_push) | (span > MAX_IDX);
  end
endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  dec_t              dec_i,
  input  logic              mem_ready_i,
  output seq_st_e           st_o,
  output logic              push_o,
  output logic              ret_o,
  output logic              bad_o,
  output logic [RIDX_W-1:0] first_o,
  output logic [RIDX_W-1:0] idx_o,
  output logic              accept_o,
  output logic              fire_o
);
  seq_st_e           st_q, st_d;
  dec_t              dec_q, dec_d;
  logic [RIDX_W-1:0] idx_q, idx_d;
  logic              mem_req, last_reg;

  assign mem_req  = (st_q == ST_RA_LO) || (st_q == ST_RA_HI) || (st_q == ST_REG);
  assign fire_o   = mem_req && mem_ready_i;
  assign accept_o = start_i && (st_q == ST_IDLE);
  assign last_reg = dec_q.push ? (idx_q == '0)
                               : (idx_q == RIDX_W'(dec_q.cnt - 1'b1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    dec_d = dec_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        dec_d = dec_i;
        if (dec_i.bad) begin
          st_d = ST_FIN;
        end else if (dec_i.push) begin
          st_d  = dec_i.with_ra ? ST_RA_LO : ST_REG;
          idx_d = RIDX_W'(dec_i.cnt - 1'b1);
        end else begin
          st_d  = ST_REG;
          idx_d = '0;
        end
      end
      ST_RA_LO: if (mem_ready_i) st_d = ST_RA_HI;
      ST_RA_HI: if (mem_ready_i) st_d = dec_q.push ? ST_REG : ST_FIN;
      ST_REG: if (mem_ready_i) begin
        if (last_reg) st_d = (!dec_q.push && dec_q.with_ra) ? ST_RA_LO : ST_FIN;
        else          idx_d = dec_q.push ? idx_q - 1'b1 : idx_q + 1'b1;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      dec_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      dec_q <= dec_d;
      idx_q <= idx_d;
    end
  end

  assign st_o    = st_q;
  assign push_o  = dec_q.push;
  assign ret_o   = dec_q.ret;
  assign bad_o   = dec_q.bad;
  assign first_o = dec_q.first;
  assign idx_o   = idx_q;
endmodule

// File: rtl/stack_seq_agu.sv
module stack_seq_agu
  import stack_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              fire_i,
  input  seq_st_e           st_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic [HW_W-1:0]   rf_rdata_i,
  input  logic [HW_W-1:0]   mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [RA_W-1:0]   ra_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [HW_W-1:0]   mem_wdata_o,
  output logic              ra_we_o,
  output logic [RA_W-1:0]   ra_wdata_o
);
  localparam logic [ADDR_W-1:0] HW_STEP = ADDR_W'(HW_W / 8);
  localparam logic [ADDR_W-1:0] RA_STEP = ADDR_W'(RA_W / 8);

  logic [ADDR_W-1:0] sp_q;
  logic [RA_W-1:0]   ra_q;
  logic [HW_W-1:0]   ra_lo_q;

  // push addresses sit below SP; SP moves only when a transfer completes
  always_comb begin
    unique case (st_i)
      ST_RA_LO: mem_addr_o = push_i ? sp_q - RA_STEP : sp_q;
      ST_RA_HI: mem_addr_o = push_i ? sp_q - RA_STEP + HW_STEP : sp_q + HW_STEP;
      ST_REG:   mem_addr_o = push_i ? sp_q - HW_STEP : sp_q;
      default:  mem_addr_o = sp_q;
    endcase
    unique case (st_i)
      ST_RA_LO: mem_wdata_o = ra_q[HW_W-1:0];
      ST_RA_HI: mem_wdata_o = ra_q[RA_W-1:HW_W];
      default:  mem_wdata_o = rf_rdata_i;
    endcase
  end

  assign ra_wdata_o = {mem_rdata_i, ra_lo_q};
  assign ra_we_o    = fire_i && !push_i && (st_i == ST_RA_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      ra_q    <= '0;
      ra_lo_q <= '0;
    end else if (accept_i) begin
      sp_q <= sp_i;
      ra_q <= ra_i;
    end else if (fire_i) begin
      unique case (st_i)
        ST_RA_LO: if (!push_i) ra_lo_q <= mem_rdata_i;
        ST_RA_HI: begin
          sp_q <= push_i ? sp_q - RA_STEP : sp_q + RA_STEP;
          if (!push_i) ra_q <= ra_wdata_o;
        end
        ST_REG:  sp_q <= push_i ? sp_q - HW_STEP : sp_q + HW_STEP;
        default: ;
      endcase
    end
  end

  assign sp_o = sp_q;
  assign ra_o = ra_q;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       insn_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [31:0]       ra_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              jump_o,
  output logic [31:0]       jump_target_o,
  output logic [3:0]        rf_addr_o,
  input  logic [15:0]       rf_rdata_i,
  output logic              rf_we_o,
  output logic [15:0]       rf_wdata_o,
  output logic              ra_we_o,
  output logic [31:0]       ra_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i,
  input  logic              mem_ready_i
);
  dec_t              dec;
  seq_st_e           st;
  logic              push, ret, bad, accept, fire;
  logic [RIDX_W-1:0] first, idx;

  stack_seq_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  stack_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dec_i       (dec),
    .mem_ready_i (mem_ready_i),
    .st_o        (st),
    .push_o      (push),
    .ret_o       (ret),
    .bad_o       (bad),
    .first_o     (first),
    .idx_o       (idx),
    .accept_o    (accept),
    .fire_o      (fire)
  );

  stack_seq_agu #(.ADDR_W(ADDR_W)) u_agu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .fire_i      (fire),
    .st_i        (st),
    .push_i      (push),
    .sp_i        (sp_i),
    .ra_i        (ra_i),
    .rf_rdata_i  (rf_rdata_i),
    .mem_rdata_i (mem_rdata_i),
    .sp_o        (sp_o),
    .ra_o        (jump_target_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .ra_we_o     (ra_we_o),
    .ra_wdata_o  (ra_wdata_o)
  );

  assign busy_o     = (st != ST_IDLE);
  assign done_o     = (st == ST_FIN);
  assign illegal_o  = done_o && bad;
  assign jump_o     = done_o && !bad && ret;
  assign mem_req_o  = (st == ST_RA_LO) || (st == ST_RA_HI) || (st == ST_REG);
  assign mem_we_o   = mem_req_o && push;
  assign rf_addr_o  = first + idx;
  assign rf_we_o    = fire && !push && (st == ST_REG);
  assign rf_wdata_o = mem_rdata_i;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              jump_o,
  input logic              rf_we_o,
  input logic              ra_we_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              mem_ready_i
);
  assert_rst_idle_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o && !mem_req_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_illegal_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(start_i) && !$past(busy_o)));

  assert_jump_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (done_o && !illegal_o));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_wdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ready_i) |=> $stable(mem_wdata_o));

  assert_req_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_rf_we_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));

  assert_ra_we_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o && !rf_we_o));
endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .jump_o      (jump_o),
  .rf_we_o     (rf_we_o),
  .ra_we_o     (ra_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] insn_i = '0;
  logic [31:0] sp_i = '0;
  logic [31:0] ra_i;
  logic        busy_o, done_o, illegal_o, jump_o;
  logic [31:0] sp_o, jump_target_o;
  logic [3:0]  rf_addr_o;
  logic [15:0] rf_rdata_i, rf_wdata_o;
  logic        rf_we_o, ra_we_o;
  logic [31:0] ra_wdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i = 1'b0;

  logic [15:0] mem [128];
  logic [15:0] rf  [16];
  logic [31:0] ra_m;
  logic [15:0] em  [128];
  logic [15:0] erf [16];
  logic [31:0] era;
  int          acc_cnt = 0;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  logic        hold_ready = 1'b0;

  always #10 clk_i = ~clk_i;

  assign ra_i        = ra_m;
  assign rf_rdata_i  = rf[rf_addr_o];
  assign mem_rdata_i = mem[mem_addr_o[7:1]];

  stack_seq dut_i (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_req_o && mem_ready_i) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we_o) mem[mem_addr_o[7:1]] <= mem_wdata_o;
    end
    if (rf_we_o) rf[rf_addr_o] <= rf_wdata_o;
    if (ra_we_o) ra_m <= ra_wdata_o;
  end

  always @(negedge clk_i)
    mem_ready_i = mem_req_o && !hold_ready && (cyc % 3 != 1);

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        summary();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mpat(int seed, int i);
    return 16'((seed * 16'h03B1) ^ (i * 16'h0107) ^ 16'h5A5A);
  endfunction
  function automatic logic [15:0] rpat(int seed, int i);
    return 16'hA000 ^ 16'(seed << 4) ^ 16'(i);
  endfunction
  function automatic logic [31:0] rapat(int seed);
    return {16'hC0DE ^ 16'(seed), 16'h1234 ^ 16'(seed * 7)};
  endfunction

  // preload models and compute expected state from R1..R10
  task automatic prep(input logic [15:0] w, input logic [31:0] sp0, input int seed,
                      output bit xbad, output bit xjump, output logic [31:0] xsp,
                      output int xacc);
    bit is_pop, is_push, wra, ret;
    int c, f, b;
    is_pop  = (w[15:9] == 7'b0000001);
    is_push = (w[15:8] == 8'b00000001);
    wra = w[7];
    ret = is_pop && w[8];
    c = int'(w[6:4]) + 1;
    f = int'(w[3:0]);
    xbad = !(is_pop || is_push) || (c + f > 15);
    for (int i = 0; i < 128; i++) begin mem[i] <= mpat(seed, i); em[i] = mpat(seed, i); end
    for (int i = 0; i < 16; i++) begin rf[i] <= rpat(seed, i); erf[i] = rpat(seed, i); end
    ra_m <= rapat(seed);
    era = rapat(seed);
    xsp = sp0; xjump = 1'b0; xacc = 0;
    if (!xbad && is_push) begin
      xsp = sp0 - 32'(2 * c) - (wra ? 32'd4 : 32'd0);
      b = int'(xsp[7:1]);
      for (int k = 0; k < c; k++) em[b + k] = rpat(seed, f + k);
      if (wra) begin em[b + c] = era[15:0]; em[b + c + 1] = era[31:16]; end
      xacc = c + (wra ? 2 : 0);
    end else if (!xbad) begin
      b = int'(sp0[7:1]);
      for (int k = 0; k < c; k++) erf[f + k] = mpat(seed, b + k);
      if (wra) era = {mpat(seed, b + c + 1), mpat(seed, b + c)};
      xsp = sp0 + 32'(2 * c) + (wra ? 32'd4 : 32'd0);
      xjump = ret;
      xacc = c + (wra ? 2 : 0);
    end
  endtask

  task automatic compare(input bit xbad, input bit xjump, input logic [31:0] xsp,
                         input int xacc, input bit a_ill, input bit a_jmp,
                         input logic [31:0] a_sp, input logic [31:0] a_tgt, input int a_acc);
    int mi, ri;
    chk(a_ill == xbad, "R3", "illegal flag", 32'(a_ill), 32'(xbad));
    chk(a_sp == xsp, "R10", "final sp", a_sp, xsp);
    chk(a_jmp == xjump, "R6", "jump flag", 32'(a_jmp), 32'(xjump));
    if (xjump) chk(a_tgt == era, "R6", "jump target", a_tgt, era);
    chk(a_acc == xacc, "R2", "handshake count", 32'(a_acc), 32'(xacc));
    mi = -1;
    for (int i = 127; i >= 0; i--) if (mem[i] !== em[i]) mi = i;
    if (mi < 0) chk(1'b1, "R7", "memory image", 0, 0);
    else chk(1'b0, "R7", "memory image", {16'(mi), mem[mi]}, {16'(mi), em[mi]});
    ri = -1;
    for (int i = 15; i >= 0; i--) if (rf[i] !== erf[i]) ri = i;
    if (ri < 0) chk(1'b1, "R4", "register file", 0, 0);
    else chk(1'b0, "R4", "register file", {16'(ri), rf[ri]}, {16'(ri), erf[ri]});
    chk(ra_m == era, "R5", "return address reg", ra_m, era);
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done_o && n < 400) begin @(negedge clk_i); n++; end
    ok = done_o;
    chk(ok, "R9", "done within limit", 32'(n), 32'd400);
  endtask

  task automatic run(input logic [15:0] w, input logic [31:0] sp0, input int seed);
    bit xbad, xjump, ok, a_ill, a_jmp;
    logic [31:0] xsp, a_sp, a_tgt;
    int xacc, base;
    @(negedge clk_i);
    prep(w, sp0, seed, xbad, xjump, xsp, xacc);
    @(negedge clk_i);
    base = acc_cnt;
    start_i = 1'b1; insn_i = w; sp_i = sp0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o || (xbad && done_o), "R9", "busy after start", 32'(busy_o), 32'd1);
    if (xbad) chk(done_o && illegal_o, "R3", "illegal done one cycle after start",
                  32'(done_o), 32'd1);
    wait_done(ok);
    a_ill = illegal_o; a_jmp = jump_o; a_sp = sp_o; a_tgt = jump_target_o;
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9", "done is one cycle", 32'(done_o), 32'd0);
    compare(xbad, xjump, xsp, xacc, a_ill, a_jmp, a_sp, a_tgt, acc_cnt - base);
  endtask

  initial begin
    bit xbad, xjump, ok;
    logic [31:0] xsp, a_sp, a_tgt, a0;
    int xacc, base, seed;
    bit a_ill, a_jmp;

    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !ra_we_o, "R11", "reset outputs",
        {busy_o, done_o, mem_req_o, rf_we_o, ra_we_o}, 32'd0);
    rst_ni = 1'b1;

    // R1: words that are neither push nor pop
    run(16'h0000, 32'h80, 1);
    run(16'h0400, 32'h80, 2);
    run(16'hF1FF, 32'h80, 3);

    seed = 10;
    // push sweep R7, pop sweep R4/R5/R6, range check R3
    for (int ra = 0; ra < 2; ra++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 16; f++) begin
          run({8'b00000001, 1'(ra), 3'(c), 4'(f)}, (seed % 2) ? 32'h40 : 32'h80, seed);
          seed++;
        end
    for (int rt = 0; rt < 2; rt++)
      for (int ra = 0; ra < 2; ra++)
        for (int c = 0; c < 8; c++)
          for (int f = 0; f < 16; f++) begin
            run({7'b0000001, 1'(rt), 1'(ra), 3'(c), 4'(f)}, (seed % 2) ? 32'h40 : 32'h80, seed);
            seed++;
          end

    // R8 stalled handshake, R9 start ignored while busy
    @(negedge clk_i);
    prep(16'h01A2, 32'h80, 999, xbad, xjump, xsp, xacc);
    hold_ready = 1'b1;
    @(negedge clk_i);
    base = acc_cnt;
    start_i = 1'b1; insn_i = 16'h01A2; sp_i = 32'h80;
    @(negedge clk_i);
    start_i = 1'b0;
    a0 = mem_addr_o;
    chk(mem_req_o && mem_we_o && a0 == 32'h7C, "R7", "first push address is sp-4",
        a0, 32'h7C);
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; insn_i = 16'h0000; sp_i = 32'h20;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(mem_req_o && mem_addr_o == a0 && !done_o, "R8", "request held while not ready",
        mem_addr_o, a0);
    chk(acc_cnt == base && mem[62] == mpat(999, 62), "R8", "no write while stalled",
        32'(acc_cnt - base), 32'd0);
    hold_ready = 1'b0;
    wait_done(ok);
    a_ill = illegal_o; a_jmp = jump_o; a_sp = sp_o; a_tgt = jump_target_o;
    @(negedge clk_i);
    chk(!a_ill, "R9", "start during busy ignored", 32'(a_ill), 32'd0);
    compare(xbad, xjump, xsp, xacc, a_ill, a_jmp, a_sp, a_tgt, acc_cnt - base);

    summary();
  end
endmodule